// File: doc/BRIEF.md
# Windowed Limit Interrupt Controller

This block watches a stream of conversion results. Each result arrives with a channel index. The block compares the result against a high limit and a low limit held for that channel, and records any excursion as a sticky flag in a status register. A separate fault input raises one more flag. A per-channel mask keeps selected sources from ever raising a flag. A single interrupt pin reports that at least one unmasked flag is pending, and a configuration bit sets whether that pin is active high or active low.

The host programs the limits, the mask and the polarity through a simple parallel write port. It reads the status register through the `status` output together with a one-cycle read strobe, and that read clears the flags. The default configuration has seven measured channels (supply voltage, internal temperature, external temperature and four analog inputs) plus the fault source. Results are 10 bits wide and limits are 8 bits wide.

A two-state machine drives the pin. In **ST_QUIET** the pin is inactive. The transition **RAISE** leads to **ST_ALERT**, where the pin is active, when any unmasked flag is pending. The transition **DROP** returns to ST_QUIET when none is pending. A soft reset forces ST_QUIET through the transition **FLUSH**.

Top module: `wlic_top`

## Requirements
- R1: During and after reset, `status` is all zero and `int_pin` is high, because the polarity defaults to active low.
- R2: A strobed result for channel c sets status bit c when its upper 8 bits are strictly greater than the channel's high limit. Equality does not set the bit. High limit c is written at address 0x10+c.
- R3: A strobed result sets status bit c when its upper 8 bits are less than or equal to the channel's low limit. Low limit c is written at address 0x18+c.
- R4: The two least significant result bits have no effect on the comparison.
- R5: When bit c of the mask register (address 0x01) is 1, status bit c can never be set.
- R6: A status bit stays set until it is cleared, even when later results for that channel are back in range. Bits become set only in a cycle with a result strobe or a fault input.
- R7: A cycle with `rd_stat` high clears the status register at the next clock edge. A flag raised in that same cycle is kept.
- R8: One clock edge after the status register holds an unmasked flag, `int_pin` is active. One edge after no unmasked flag is pending, `int_pin` is inactive. Configuration register (address 0x02) bit 0 selects the active level: 1 means active high, 0 means active low.
- R9: `diode_fault` high sets status bit 7 unless mask bit 7 is 1.
- R10: Writing the configuration register with bit 7 set clears all flags, sets every high limit to 0xFF and every low limit to 0x00, clears the mask, and selects active-low polarity.
- R11: A strobe whose channel index is 7 or above changes nothing. A write to address 0x00 leaves the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Result strobe, one cycle per result |
| res_chan | input | 3 | Channel index of the result |
| res_data | input | 10 | Conversion result |
| diode_fault | input | 1 | Fault condition, raises flag bit 7 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_stat | input | 1 | Status read strobe, clears the flags |
| status | output | 8 | Sticky flag register |
| int_pin | output | 1 | Interrupt output with programmable polarity |

## Verification
The bound checker watches several rules on every clock. Flags may only appear in a cycle with a result strobe or a fault input. Flags never vanish without a read or a soft reset. A read or a soft reset empties the register. The pin level always matches the previous cycle's pending state under the current polarity. The exact window boundaries, the indifference to the two low result bits, the mask, the fault source and the defaults restored by a soft reset depend on limit values the checker cannot see. Only the bench's sweeps over every upper-byte value on every channel, and its directed scenarios, can show those.

// File: rtl/wlic_pkg.sv
package wlic_pkg;

    localparam int unsigned ADDR_W = 6;
    localparam int unsigned DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_STATUS  = 6'h00;
    localparam logic [ADDR_W-1:0] A_MASK    = 6'h01;
    localparam logic [ADDR_W-1:0] A_CFG     = 6'h02;
    localparam logic [ADDR_W-1:0] A_HI_BASE = 6'h10;
    localparam logic [ADDR_W-1:0] A_LO_BASE = 6'h18;

    localparam int unsigned CFG_POL_BIT  = 0;
    localparam int unsigned CFG_SRST_BIT = 7;

    typedef enum logic [0:0] {
        ST_QUIET = 1'b0,
        ST_ALERT = 1'b1
    } irq_state_e;

endpackage

// File: rtl/wlic_regs.sv
module wlic_regs
    import wlic_pkg::*;
#(
    parameter int NUM_CH = 7,
    parameter int LIM_W  = 8,
    parameter int FLAG_W = NUM_CH + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [NUM_CH-1:0][LIM_W-1:0] hi_lim,
    output logic [NUM_CH-1:0][LIM_W-1:0] lo_lim,
    output logic [FLAG_W-1:0]       mask_q,
    output logic                    pol_q,
    output logic                    soft_rst
);

    logic cfg_wr;
    logic mask_wr;

    assign cfg_wr   = wr_en && (wr_addr == A_CFG);
    assign mask_wr  = wr_en && (wr_addr == A_MASK);
    assign soft_rst = cfg_wr && wr_data[CFG_SRST_BIT];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lim
        logic hi_sel;
        logic lo_sel;

        assign hi_sel = wr_en && (wr_addr == (A_HI_BASE + ADDR_W'(g)));
        assign lo_sel = wr_en && (wr_addr == (A_LO_BASE + ADDR_W'(g)));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hi_lim[g] <= '1;
                lo_lim[g] <= '0;
            end else if (soft_rst) begin
                hi_lim[g] <= '1;
                lo_lim[g] <= '0;
            end else begin
                if (hi_sel) hi_lim[g] <= wr_data[LIM_W-1:0];
                if (lo_sel) lo_lim[g] <= wr_data[LIM_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            pol_q  <= 1'b0;
        end else if (soft_rst) begin
            mask_q <= '0;
            pol_q  <= 1'b0;
        end else begin
            if (mask_wr) mask_q <= wr_data[FLAG_W-1:0];
            if (cfg_wr)  pol_q  <= wr_data[CFG_POL_BIT];
        end
    end

endmodule

// File: rtl/wlic_window_cmp.sv
module wlic_window_cmp #(
    parameter int NUM_CH = 7,
    parameter int RES_W  = 10,
    parameter int LIM_W  = 8,
    parameter int CH_W   = 3
) (
    input  logic                         res_valid,
    input  logic [CH_W-1:0]              res_chan,
    input  logic [RES_W-1:0]             res_data,
    input  logic [NUM_CH-1:0][LIM_W-1:0] hi_lim,
    input  logic [NUM_CH-1:0][LIM_W-1:0] lo_lim,
    input  logic [NUM_CH-1:0]            ch_mask,
    output logic [NUM_CH-1:0]            hit
);

    localparam int DROP_W = RES_W - LIM_W;

    logic [LIM_W-1:0] res_top;
    logic             unused_lsbs;

    assign res_top     = res_data[RES_W-1 -: LIM_W];
    assign unused_lsbs = ^res_data[DROP_W-1:0];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
        logic sel;
        logic above;
        logic below;

        assign sel    = res_valid && (res_chan == CH_W'(g));
        assign above  = res_top >  hi_lim[g];
        assign below  = res_top <= lo_lim[g];
        assign hit[g] = sel && (above || below) && !ch_mask[g];
    end

endmodule

// File: rtl/wlic_flag_bank.sv
module wlic_flag_bank #(
    parameter int FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_vec,
    input  logic              rd_stat,
    input  logic              soft_rst,
    output logic [FLAG_W-1:0] flags_q
);

    logic [FLAG_W-1:0] kept;

    always_comb begin
        kept = rd_stat ? '0 : flags_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (soft_rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= kept | set_vec;
        end
    end

endmodule

// File: rtl/wlic_irq_fsm.sv
module wlic_irq_fsm
    import wlic_pkg::*;
#(
    parameter int FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] flags,
    input  logic [FLAG_W-1:0] mask,
    input  logic              pol,
    input  logic              soft_rst,
    output logic              int_pin
);

    irq_state_e state_q;
    irq_state_e state_d;
    logic       pending;

    assign pending = |(flags & ~mask);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: if (pending)  state_d = ST_ALERT;
            ST_ALERT: if (!pending) state_d = ST_QUIET;
        endcase
        if (soft_rst) state_d = ST_QUIET;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_QUIET: int_pin = !pol;
            ST_ALERT: int_pin = pol;
        endcase
    end

endmodule

// File: rtl/wlic_top.sv
module wlic_top
    import wlic_pkg::*;
#(
    parameter  int NUM_CH = 7,
    parameter  int RES_W  = 10,
    parameter  int LIM_W  = 8,
    localparam int CH_W   = $clog2(NUM_CH + 1),
    localparam int FLAG_W = NUM_CH + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [CH_W-1:0]   res_chan,
    input  logic [RES_W-1:0]  res_data,
    input  logic              diode_fault,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stat,
    output logic [FLAG_W-1:0] status,
    output logic              int_pin
);

    logic [NUM_CH-1:0][LIM_W-1:0] hi_lim;
    logic [NUM_CH-1:0][LIM_W-1:0] lo_lim;
    logic [FLAG_W-1:0]            mask_q;
    logic                         pol_q;
    logic                         soft_rst;
    logic [NUM_CH-1:0]            ch_hit;
    logic [FLAG_W-1:0]            set_vec;
    logic [FLAG_W-1:0]            flags_q;

    wlic_regs #(
        .NUM_CH (NUM_CH),
        .LIM_W  (LIM_W),
        .FLAG_W (FLAG_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .hi_lim   (hi_lim),
        .lo_lim   (lo_lim),
        .mask_q   (mask_q),
        .pol_q    (pol_q),
        .soft_rst (soft_rst)
    );

    wlic_window_cmp #(
        .NUM_CH (NUM_CH),
        .RES_W  (RES_W),
        .LIM_W  (LIM_W),
        .CH_W   (CH_W)
    ) u_cmp (
        .res_valid (res_valid),
        .res_chan  (res_chan),
        .res_data  (res_data),
        .hi_lim    (hi_lim),
        .lo_lim    (lo_lim),
        .ch_mask   (mask_q[NUM_CH-1:0]),
        .hit       (ch_hit)
    );

    assign set_vec = {diode_fault && !mask_q[NUM_CH], ch_hit};

    wlic_flag_bank #(
        .FLAG_W (FLAG_W)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .rd_stat  (rd_stat),
        .soft_rst (soft_rst),
        .flags_q  (flags_q)
    );

    wlic_irq_fsm #(
        .FLAG_W (FLAG_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .flags    (flags_q),
        .mask     (mask_q),
        .pol      (pol_q),
        .soft_rst (soft_rst),
        .int_pin  (int_pin)
    );

    assign status = flags_q;

endmodule

// File: rtl/wlic_chk.sv
module wlic_chk
    import wlic_pkg::*;
#(
    parameter int FLAG_W = 8,
    parameter int CH_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              res_valid,
    input logic              diode_fault,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_stat,
    input logic [FLAG_W-1:0] status,
    input logic              int_pin,
    input logic [FLAG_W-1:0] mask,
    input logic              pol
);

    logic srst_wr;
    assign srst_wr = wr_en && (wr_addr == A_CFG) && wr_data[CFG_SRST_BIT];

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (status == '0));

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stat && !srst_wr) |=> ((status & $past(status)) == $past(status)));

    // R6
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && !diode_fault) |=> ((status & ~$past(status)) == '0));

    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !res_valid && !diode_fault) |=> (status == '0));

    // R10
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_wr |=> (status == '0));

    // R8
    pin_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !srst_wr |=> (int_pin == ($past(|(status & ~mask)) ~^ pol)));

endmodule

bind wlic_top wlic_chk #(
    .FLAG_W (FLAG_W),
    .CH_W   (CH_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .res_valid   (res_valid),
    .diode_fault (diode_fault),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_stat     (rd_stat),
    .status      (status),
    .int_pin     (int_pin),
    .mask        (mask_q),
    .pol         (pol_q)
);

// File: tb/tb_wlic_top.sv
module tb_wlic_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       res_valid = 1'b0;
    logic [2:0] res_chan = '0;
    logic [9:0] res_data = '0;
    logic       diode_fault = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_stat = 1'b0;
    logic [7:0] status;
    logic       int_pin;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    wlic_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .res_valid   (res_valid),
        .res_chan    (res_chan),
        .res_data    (res_data),
        .diode_fault (diode_fault),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_stat     (rd_stat),
        .status      (status),
        .int_pin     (int_pin)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send(input int ch, input logic [9:0] v);
        res_valid = 1'b1; res_chan = 3'(ch); res_data = v;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic rd();
        rd_stat = 1'b1;
        @(negedge clk);
        rd_stat = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(status == 8'h00, "R1 status", status, 0);
        check(int_pin == 1'b1, "R1 pin", int_pin, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(status == 8'h00 && int_pin, "R1 after release", {status, int_pin}, 1);

        // R2 R3 R4: every upper byte on every channel, varying low bits
        for (int ch = 0; ch < 7; ch++) begin
            int hi = 8'h90 - ch * 8;
            int lo = 8'h20 + ch * 4;
            wr(6'h10 + 6'(ch), 8'(hi));
            wr(6'h18 + 6'(ch), 8'(lo));
            for (int u = 0; u < 256; u++) begin
                logic [9:0] v = {8'(u), 2'(u ^ ch)};
                bit exp = (u > hi) || (u <= lo);
                send(ch, v);
                check(status == (8'(exp) << ch), "R2/R3/R4 window", status, 8'(exp) << ch);
                if (status != 0) rd();
            end
        end
        @(negedge clk);

        // R4 explicit boundaries on channel 0 (hi 0x90, lo 0x20)
        send(0, {8'h90, 2'b11});
        check(status == 8'h00, "R4 equal high ignores lsbs", status, 0);
        send(0, {8'h20, 2'b11});
        check(status == 8'h01, "R4 equal low ignores lsbs", status, 1);
        rd();
        @(negedge clk);

        // R8 active low
        send(1, 10'h3FC);
        check(int_pin == 1'b1, "R8 not yet", int_pin, 1);
        @(negedge clk);
        check(int_pin == 1'b0, "R8 active low asserted", int_pin, 0);
        // R6 sticky with in-range result
        send(1, 10'h200);
        check(status == 8'h02, "R6 sticky", status, 2);
        rd();
        check(status == 8'h00, "R7 read clear", status, 0);
        @(negedge clk);
        check(int_pin == 1'b1, "R8 released", int_pin, 1);

        // R8 active high
        wr(6'h02, 8'h01);
        check(int_pin == 1'b0, "R8 idle high polarity", int_pin, 0);
        send(1, 10'h3FC);
        @(negedge clk);
        check(int_pin == 1'b1, "R8 active high asserted", int_pin, 1);
        rd();
        @(negedge clk);
        check(int_pin == 1'b0, "R8 active high released", int_pin, 0);
        wr(6'h02, 8'h00);

        // R7 set wins over read in same cycle
        send(0, 10'h3FC);
        rd_stat = 1'b1; res_valid = 1'b1; res_chan = 3'd2; res_data = 10'h3FC;
        @(negedge clk);
        rd_stat = 1'b0; res_valid = 1'b0;
        check(status == 8'h04, "R7 set kept over read", status, 4);
        rd();

        // R5 mask
        wr(6'h01, 8'h08);
        send(3, 10'h3FC);
        check(status == 8'h00, "R5 masked channel", status, 0);
        @(negedge clk);
        check(int_pin == 1'b1, "R5 masked no pin", int_pin, 1);
        send(4, 10'h3FC);
        check(status == 8'h10, "R5 unmasked neighbour", status, 8'h10);
        rd();

        // R9 fault source
        wr(6'h01, 8'h80);
        diode_fault = 1'b1; @(negedge clk); diode_fault = 1'b0;
        check(status == 8'h00, "R9 fault masked", status, 0);
        wr(6'h01, 8'h00);
        diode_fault = 1'b1; @(negedge clk); diode_fault = 1'b0;
        check(status == 8'h80, "R9 fault flag", status, 8'h80);
        @(negedge clk);
        check(int_pin == 1'b0, "R9 fault pin", int_pin, 0);
        rd();

        // R11 out-of-range channel and status write
        send(7, 10'h3FC);
        check(status == 8'h00, "R11 channel 7 ignored", status, 0);
        send(0, 10'h3FC);
        wr(6'h00, 8'h00);
        check(status == 8'h01, "R11 status write ignored", status, 1);

        // R10 soft reset
        wr(6'h01, 8'h02);
        wr(6'h02, 8'h81);
        check(status == 8'h00, "R10 flags cleared", status, 0);
        @(negedge clk);
        check(int_pin == 1'b1, "R10 polarity low", int_pin, 1);
        send(0, 10'h3FF);
        check(status == 8'h00, "R10 high limit FF", status, 0);
        send(0, 10'h003);
        check(status == 8'h01, "R10 low limit 00", status, 1);
        send(1, 10'h000);
        check(status == 8'h03, "R10 mask cleared", status, 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule